// File: doc/BRIEF.md
# Paged Host Register Interface

This block gives a host processor access to a large bank of control and status registers over a five-bit address bus and an eight-bit data path. Access takes two steps. The host first writes a page number into a page register, which it reaches with the top address bit low. It then reaches one of sixteen registers in that page with the top address bit high and the low four bits as the index. The page number stays in place until the host writes it again, so a run of accesses within one page needs only one page write.

A mode pin chooses the strobe convention. In one convention the bus has separate active-low read and write strobes. In the other it has a single direction line and an active-low data strobe. All pins are sampled on the system clock. A write commits once per strobe assertion. Read data comes out through a registered output. Each page index is either writable or read-only. Writable registers drive a flat control vector to the rest of the chip. Read-only registers return status bits supplied by that logic.

Top module: `pgreg_ctl`

## Requirements
- R1: With `intel_mode`=1, `cs_n`=0 and `wr_n`=0 (`rd_n`=1), the data is written. With `rd_n`=0 (`wr_n`=1), read data appears on `rdata` two clock edges after the strobe is first sampled.
- R2: With `intel_mode`=0, `cs_n`=0 and `ds_n`=0, `rw`=0 performs a write and `rw`=1 performs a read. Timing is the same as in R1.
- R3: In one strobe mode, the strobes of the other mode have no effect: `ds_n`/`rw` when `intel_mode`=1, and `rd_n`/`wr_n` when `intel_mode`=0.
- R4: An access with `addr[4]`=0 reaches the page register. A write stores `wdata` as the page, and the value stays until the next such write. A read returns the full stored page number.
- R5: An access with `addr[4]`=1 reaches register `addr[3:0]` of the current page. Each page/index pair is a distinct register, and it appears in `ctrl_o` at bits `((page-1)*16+index)*8 +: 8`.
- R6: Indices 12 to 15 of every page are read-only. Writes to them are ignored, their `ctrl_o` slice is zero, and reads return the matching `sts_i` slice.
- R7: When the page number is 0 or greater than 15, register reads return 0 and register writes change nothing.
- R8: `rdata` is 0 whenever no read was sampled on the previous edge.
- R9: Synchronous reset `rst` clears the page register, every writable register and `rdata` to 0.
- R10: `addr[3:0]` has no effect on an access to the page register.
- R11: When `intel_mode`=1 and `rd_n` and `wr_n` are both low, no access occurs: nothing is written and `rdata` stays 0.
- R12: A strobe held for several cycles commits exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| intel_mode | input | 1 | 1: separate read/write strobes, 0: direction line plus data strobe |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low (separate-strobe mode) |
| wr_n | input | 1 | Write strobe, active low (separate-strobe mode) |
| rw | input | 1 | Direction, 1 read / 0 write (data-strobe mode) |
| ds_n | input | 1 | Data strobe, active low (data-strobe mode) |
| addr | input | 5 | Bit 4 selects page register (0) or page register file (1); bits 3:0 register index |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Registered read data to host |
| sts_i | input | 1920 | Status values for read-only slots, 8 bits per slot |
| ctrl_o | output | 1920 | Writable register contents, 8 bits per slot |

## Verification
The hardest case to reach is the one where a write goes nowhere: a write with no valid page selected, or a write while the strobes of the inactive convention toggle. The register file has 240 slots, and the failure shows up only in a slot that nobody reads. The stimulus first fills every slot in both strobe modes. It then issues these stray accesses and compares the whole control vector against a model held in the bench. A register that was wrongly touched therefore shows up wherever it is.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

endpackage

// File: rtl/pgreg_bus_front.sv
module pgreg_bus_front
  import pgreg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              intel_mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rw,
  input  logic              ds_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_act,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  acc_e kind_d, kind_q, kind_qq;

  always_comb begin
    kind_d = ACC_IDLE;
    if (!cs_n) begin
      if (intel_mode) begin
        if (!rd_n && wr_n)      kind_d = ACC_READ;
        else if (rd_n && !wr_n) kind_d = ACC_WRITE;
      end else if (!ds_n) begin
        kind_d = rw ? ACC_READ : ACC_WRITE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= ACC_IDLE;
      kind_qq <= ACC_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      kind_q  <= kind_d;
      kind_qq <= kind_q;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  assign rd_act = (kind_q == ACC_READ);
  assign wr_stb = (kind_q == ACC_WRITE) && (kind_qq != ACC_WRITE);

endmodule

// File: rtl/pgreg_page_sel.sv
module pgreg_page_sel #(
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 15,
  localparam int PG_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              sel_reg,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] page_q,
  output logic [PG_W-1:0]   page_lo,
  output logic              page_ok
);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      page_ok <= 1'b0;
    end else if (wr_stb && !sel_reg) begin
      page_q  <= wdata;
      page_ok <= (wdata != '0) && (wdata <= DATA_W'(NUM_PAGES));
    end
  end

  assign page_lo = page_q[PG_W-1:0];

endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank #(
  parameter int          DATA_W    = 8,
  parameter int          NUM_PAGES = 15,
  parameter int          IDX_W     = 4,
  parameter logic [15:0] RO_MASK   = 16'hF000,
  localparam int REGS      = 1 << IDX_W,
  localparam int NUM_SLOTS = NUM_PAGES * REGS,
  localparam int PG_W      = $clog2(NUM_PAGES + 1),
  localparam int VIEW_N    = 1 << (PG_W + IDX_W)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        page_ok,
  input  logic [PG_W-1:0]             page_lo,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] sts_i,
  output logic [NUM_SLOTS*DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0]           rd_word
);

  logic [PG_W+IDX_W-1:0] slot_sel;
  logic [DATA_W-1:0]     view [VIEW_N];

  assign slot_sel = {page_lo - 1'b1, idx};

  for (genvar s = 0; s < VIEW_N; s++) begin : g_slot
    if (s >= NUM_SLOTS) begin : g_pad
      assign view[s] = '0;
    end else if (RO_MASK[s % REGS]) begin : g_ro
      assign view[s] = sts_i[s*DATA_W +: DATA_W];
      assign ctrl_o[s*DATA_W +: DATA_W] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      logic              unused_sts;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wr_en && page_ok && (slot_sel == (PG_W+IDX_W)'(s))) begin
          q <= wdata;
        end
      end
      assign view[s]                    = q;
      assign ctrl_o[s*DATA_W +: DATA_W] = q;
      assign unused_sts                 = ^sts_i[s*DATA_W +: DATA_W];
    end
  end

  assign rd_word = page_ok ? view[slot_sel] : '0;

endmodule

// File: rtl/pgreg_ctl.sv
module pgreg_ctl #(
  parameter int          DATA_W    = 8,
  parameter int          NUM_PAGES = 15,
  parameter int          IDX_W     = 4,
  parameter logic [15:0] RO_MASK   = 16'hF000,
  localparam int ADDR_W    = IDX_W + 1,
  localparam int NUM_SLOTS = NUM_PAGES * (1 << IDX_W),
  localparam int PG_W      = $clog2(NUM_PAGES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        intel_mode,
  input  logic                        cs_n,
  input  logic                        rd_n,
  input  logic                        wr_n,
  input  logic                        rw,
  input  logic                        ds_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] sts_i,
  output logic [NUM_SLOTS*DATA_W-1:0] ctrl_o
);

  logic              rd_act, wr_stb, sel_reg, page_ok;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, page_q, bank_word;
  logic [PG_W-1:0]   page_lo;

  pgreg_bus_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .intel_mode(intel_mode), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .rw(rw), .ds_n(ds_n),
    .addr(addr), .wdata(wdata),
    .rd_act(rd_act), .wr_stb(wr_stb), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  assign sel_reg = addr_q[ADDR_W-1];

  pgreg_page_sel #(.DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES)) u_page (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel_reg(sel_reg),
    .wdata(wdata_q), .page_q(page_q), .page_lo(page_lo), .page_ok(page_ok)
  );

  pgreg_bank #(
    .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .RO_MASK(RO_MASK)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_stb && sel_reg), .page_ok(page_ok),
    .page_lo(page_lo), .idx(addr_q[IDX_W-1:0]), .wdata(wdata_q),
    .sts_i(sts_i), .ctrl_o(ctrl_o), .rd_word(bank_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_act) rdata <= sel_reg ? bank_word : page_q;
    else             rdata <= '0;
  end

endmodule

// File: rtl/pgreg_ctl_chk.sv
module pgreg_ctl_chk #(
  parameter int          DATA_W    = 8,
  parameter int          NUM_PAGES = 15,
  parameter int          IDX_W     = 4,
  parameter logic [15:0] RO_MASK   = 16'hF000,
  localparam int NUM_SLOTS = NUM_PAGES * (1 << IDX_W)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        rd_act,
  input logic                        wr_stb,
  input logic                        sel_reg,
  input logic                        page_ok,
  input logic [DATA_W-1:0]           page_q,
  input logic [DATA_W-1:0]           rdata,
  input logic [NUM_SLOTS*DATA_W-1:0] ctrl_o
);

  logic [NUM_SLOTS-1:0] ro_hits;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ro
    if (RO_MASK[s % (1 << IDX_W)]) begin : g_on
      assign ro_hits[s] = |ctrl_o[s*DATA_W +: DATA_W];
    end else begin : g_off
      assign ro_hits[s] = 1'b0;
    end
  end

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && !sel_reg) |=> $stable(page_q));

  // R4
  page_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_act && !sel_reg) |=> (rdata == $past(page_q)));

  // R7
  bad_page_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_act && sel_reg && !page_ok) |=> (rdata == '0));

  // R7
  bad_page_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && sel_reg && !page_ok) |=> $stable(ctrl_o));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> (rdata == '0));

  // R6
  ro_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ro_hits == '0);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (page_q == '0 && rdata == '0 && ctrl_o == '0));

endmodule

bind pgreg_ctl pgreg_ctl_chk #(
  .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .RO_MASK(RO_MASK)
) u_chk (
  .clk(clk), .rst(rst), .rd_act(rd_act), .wr_stb(wr_stb), .sel_reg(sel_reg),
  .page_ok(page_ok), .page_q(page_q), .rdata(rdata), .ctrl_o(ctrl_o)
);

// File: tb/pgreg_ctl_test.sv
module pgreg_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 15;
  localparam int NS = NP * 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic intel_mode = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NS*8-1:0] sts_i;
  logic [NS*8-1:0] ctrl_o;

  logic [7:0] model [1:15][0:15];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgreg_ctl uut (
    .clk(clk), .rst(rst), .intel_mode(intel_mode), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .rw(rw), .ds_n(ds_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sts_i(sts_i), .ctrl_o(ctrl_o)
  );

  function automatic logic [7:0] sts_val(int p, int i);
    return 8'(((p - 1) * 16 + i) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] wval(int p, int i, int salt);
    return 8'(p * 29 + i * 7 + salt);
  endfunction

  function automatic bit is_ro(int i);
    return i >= 12;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(bit intel, bit wr, logic [4:0] a, logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    intel_mode = intel; addr = a; wdata = d; cs_n = 1'b0;
    if (intel) begin rd_n = wr; wr_n = !wr; end
    else begin rw = !wr; ds_n = 1'b0; end
    repeat (3) @(negedge clk);
    q = rdata;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_ctrl(string req);
    for (int p = 1; p <= NP; p++)
      for (int i = 0; i < 16; i++)
        chk(req, ctrl_o[((p-1)*16+i)*8 +: 8], is_ro(i) ? 8'h00 : model[p][i]);
  endtask

  task automatic fill(bit intel, int salt, string req);
    logic [7:0] q;
    for (int p = 1; p <= NP; p++) begin
      acc(intel, 1'b1, {1'b0, 4'(p * 3)}, 8'(p), q);   // R10: junk low bits
      for (int i = 0; i < 16; i++) begin
        acc(intel, 1'b1, {1'b1, 4'(i)}, wval(p, i, salt), q);
        if (!is_ro(i)) model[p][i] = wval(p, i, salt);
      end
    end
  endtask

  task automatic readback(bit intel, bit descend, string req);
    logic [7:0] q;
    for (int k = 0; k < NP; k++) begin
      int p = descend ? NP - k : k + 1;
      acc(intel, 1'b1, 5'h00, 8'(p), q);
      acc(intel, 1'b0, {1'b0, 4'(15 - k)}, 8'h00, q);
      chk("R4/R10 page readback", q, 8'(p));
      for (int i = 0; i < 16; i++) begin
        acc(intel, 1'b0, {1'b1, 4'(i)}, 8'h00, q);
        chk(is_ro(i) ? "R6 read-only read" : req, q,
            is_ro(i) ? sts_val(p, i) : model[p][i]);
        chk("R8 idle rdata", rdata, 8'h00);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int bad_pages [3] = '{0, 16, 200};
    for (int s = 0; s < NS; s++) sts_i[s*8 +: 8] = sts_val(s / 16 + 1, s % 16);
    for (int p = 1; p <= NP; p++) for (int i = 0; i < 16; i++) model[p][i] = 8'h00;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset rdata", rdata, 8'h00);
    check_ctrl("R9 reset registers");
    acc(1'b1, 1'b0, 5'h00, 8'h00, q);
    chk("R9 reset page", q, 8'h00);

    // R1 R5 R6 R10: separate-strobe fill and readback
    fill(1'b1, 3, "R1");
    readback(1'b1, 1'b1, "R1/R5 intel readback");
    check_ctrl("R5 ctrl_o map");

    // R2: data-strobe fill and readback
    fill(1'b0, 101, "R2");
    readback(1'b0, 1'b0, "R2/R5 motorola readback");
    check_ctrl("R2 ctrl_o map");

    // R3: inactive-mode strobes ignored
    acc(1'b0, 1'b1, 5'h00, 8'd4, q);
    @(negedge clk);
    intel_mode = 1'b0; cs_n = 1'b0; wr_n = 1'b0; addr = 5'h12; wdata = 8'hEE;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 rd_n ignored", rdata, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    intel_mode = 1'b1; cs_n = 1'b0; ds_n = 1'b0; rw = 1'b0; addr = 5'h13; wdata = 8'hDD;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
    repeat (2) @(negedge clk);
    acc(1'b1, 1'b0, 5'h12, 8'h00, q);
    chk("R3 wr_n ignored", q, model[4][2]);
    acc(1'b1, 1'b0, 5'h13, 8'h00, q);
    chk("R3 ds_n ignored", q, model[4][3]);

    // R11: both strobes low
    @(negedge clk);
    intel_mode = 1'b1; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 5'h11; wdata = 8'h77;
    repeat (4) @(negedge clk);
    chk("R11 rdata with both strobes", rdata, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    acc(1'b1, 1'b0, 5'h11, 8'h00, q);
    chk("R11 no write", q, model[4][1]);

    // R12: long strobe writes once (second value arrives mid-strobe)
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 5'h15; wdata = 8'h3C;
    repeat (4) @(negedge clk);
    wdata = 8'hC3;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    model[4][5] = 8'h3C;
    acc(1'b1, 1'b0, 5'h15, 8'h00, q);
    chk("R12 single commit", q, 8'h3C);

    // R7: pages out of range
    foreach (bad_pages[b]) begin
      acc(1'b1, 1'b1, 5'h00, 8'(bad_pages[b]), q);
      acc(1'b0, 1'b0, 5'h00, 8'h00, q);
      chk("R4 page full width", q, 8'(bad_pages[b]));
      for (int i = 0; i < 16; i += 5) begin
        acc(1'b1, 1'b1, {1'b1, 4'(i)}, 8'h99, q);
        acc(1'b1, 1'b0, {1'b1, 4'(i)}, 8'h00, q);
        chk("R7 bad page read", q, 8'h00);
      end
    end
    check_ctrl("R7 bad page write");

    // R9: reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    for (int p = 1; p <= NP; p++) for (int i = 0; i < 16; i++) model[p][i] = 8'h00;
    check_ctrl("R9 reset clears");
    acc(1'b1, 1'b0, 5'h00, 8'h00, q);
    chk("R9 page cleared", q, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule